// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block gathers error reports from four ECC decoders. Each decoder checks one 64-bit lane of a 256-bit read datapath: lane n covers data bits 64n+63 down to 64n. For every lane the block keeps three sticky flags, one each for a single-bit error, a double-bit error and an address-mismatch error. The twelve flags form the low bits of one 32-bit register that software can read.

The decoders report on each data beat with one-cycle error pulses. A beat-valid strobe qualifies those pulses. A flag is set on the first errored beat and then stays set until software writes a 1 to that bit. Writing 0 to a bit leaves it alone. No enable or mode control can clear a flag. Only the active-low asynchronous reset and a software write-one-to-clear change a flag back to 0. The read port returns the current register value at all times.

Top module: `ecc_err_status`

## Requirements
- R1: After the active-low asynchronous reset, all 32 bits of `csr_rdata` read 0.
- R2: Field layout. Bit n is the single-bit-error flag of lane n. Bit 4+n is the address-mismatch flag of lane n. Bit 8+n is the double-bit-error flag of lane n (n = 0..3, lane n covers data bits 64n+63:64n).
- R3: An error pulse present while `beat_vld` is high at a rising clock edge sets the matching flag, and the flag is visible on `csr_rdata` right after that edge.
- R4: Error pulses present while `beat_vld` is low are ignored, and no flag changes.
- R5: A set flag holds its value. Further errors of the same kind on the same lane do not change it.
- R6: A write (`csr_wr` high) with a 1 at a flag's bit position clears that flag at the same rising edge.
- R7: Writing 0 to a flag's bit position leaves the flag unchanged, and a write never sets a flag.
- R8: If a valid error and a write-one-to-clear hit the same bit in the same cycle, the flag ends as 1.
- R9: Bits 31 to 12 always read 0, and writes to them have no effect on any bit.
- R10: Flags of different lanes and kinds are independent. Setting or clearing one bit leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_vld | input | 1 | Qualifies the error pulses of the current beat |
| sbe_pulse | input | 4 | Single-bit error reported per lane (bit n = lane n) |
| adr_pulse | input | 4 | Address-mismatch error reported per lane |
| dbe_pulse | input | 4 | Double-bit error reported per lane |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Write data; a 1 clears the flag at that bit |
| csr_rdata | output | 32 | Current register value |

## Verification
Each flag is a single register that drives its readback bit with no logic in between. A wrong next-state choice therefore shows on `csr_rdata` in the cycle after the edge that caused it: a missed set, a lost clear, a clear that beats a simultaneous set, or a bit that creeps in from an invalid beat or a reserved write. The bench keeps its own 12-bit model of the register and compares the whole 32-bit word after every cycle. A fault in the bit placement or in lane independence shows up as a mismatch in a neighbouring bit within one cycle.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
    localparam int unsigned NLANE  = 4;
    localparam int unsigned KINDS  = 3;
    localparam int unsigned LANE_W = 64;
    // kind index inside a lane; the register groups kinds in this order
    localparam int unsigned K_SBE  = 0;
    localparam int unsigned K_ADR  = 1;
    localparam int unsigned K_DBE  = 2;

    typedef logic [KINDS-1:0] kind_vec_t;

    typedef struct packed {
        kind_vec_t flg;
    } lane_state_t;
endpackage

// File: rtl/ecc_lane_flags.sv
module ecc_lane_flags
    import ecc_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      beat_vld,
    input  kind_vec_t err,
    input  kind_vec_t clr,
    output kind_vec_t flg
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < KINDS; k++) begin
            if (clr[k]) st_d.flg[k] = 1'b0;
            // a set in the same cycle overrides the clear
            if (beat_vld && err[k]) st_d.flg[k] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flg = st_q.flg;

    for (genvar k = 0; k < KINDS; k++) begin : g_chk
        assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_vld && err[k]) |=> flg[k]);
        assert_setwins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (beat_vld && err[k] && clr[k]) |=> flg[k]);
        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flg[k] && !clr[k]) |=> flg[k]);
        assert_noset_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!flg[k] && !(beat_vld && err[k])) |=> !flg[k]);
        assert_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !(beat_vld && err[k])) |=> !flg[k]);
    end
endmodule

// File: rtl/ecc_stat_map.sv
module ecc_stat_map
    import ecc_stat_pkg::*;
#(
    parameter int unsigned LANES = NLANE,
    parameter int unsigned REG_W = 32
) (
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wdata,
    input  logic [LANES-1:0][KINDS-1:0]  flg,
    output logic [LANES-1:0][KINDS-1:0]  clr,
    output logic [REG_W-1:0]             rdata
);
    localparam int unsigned FLAG_W = LANES * KINDS;

    // bit position = kind * LANES + lane
    always_comb begin
        rdata = '0;
        clr   = '0;
        for (int k = 0; k < KINDS; k++) begin
            for (int l = 0; l < LANES; l++) begin
                rdata[k*LANES + l] = flg[l][k];
                clr[l][k]          = wr_en && wdata[k*LANES + l];
            end
        end
    end

    logic unused_rsvd;
    assign unused_rsvd = ^wdata[REG_W-1:FLAG_W];
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
    import ecc_stat_pkg::*;
#(
    parameter int unsigned LANES = NLANE,
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_vld,
    input  logic [LANES-1:0] sbe_pulse,
    input  logic [LANES-1:0] adr_pulse,
    input  logic [LANES-1:0] dbe_pulse,
    input  logic             csr_wr,
    input  logic [REG_W-1:0] csr_wdata,
    output logic [REG_W-1:0] csr_rdata
);
    localparam int unsigned FLAG_W = LANES * KINDS;

    logic [LANES-1:0][KINDS-1:0] flg_all;
    logic [LANES-1:0][KINDS-1:0] clr_all;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        kind_vec_t err_l;
        always_comb begin
            err_l        = '0;
            err_l[K_SBE] = sbe_pulse[l];
            err_l[K_ADR] = adr_pulse[l];
            err_l[K_DBE] = dbe_pulse[l];
        end

        ecc_lane_flags u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat_vld (beat_vld),
            .err      (err_l),
            .clr      (clr_all[l]),
            .flg      (flg_all[l])
        );
    end

    ecc_stat_map #(.LANES(LANES), .REG_W(REG_W)) u_map (
        .wr_en (csr_wr),
        .wdata (csr_wdata),
        .flg   (flg_all),
        .clr   (clr_all),
        .rdata (csr_rdata)
    );

    // a write touching only reserved bits, with no valid beat, changes nothing
    assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[FLAG_W-1:0] == '0 && !beat_vld) |=> $stable(csr_rdata));
    // without a write, the readback can only gain bits
    assert_nowr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> ((csr_rdata & $past(csr_rdata)) == $past(csr_rdata)));
endmodule

// File: tb/sim_ecc_err_status.sv
module sim_ecc_err_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_vld = 1'b0;
    logic [3:0]  sbe_pulse = '0, adr_pulse = '0, dbe_pulse = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    logic [11:0] model = '0;

    always #4 clk = ~clk;

    ecc_err_status u0 (
        .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld),
        .sbe_pulse(sbe_pulse), .adr_pulse(adr_pulse), .dbe_pulse(dbe_pulse),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    task automatic check(input logic [31:0] exp, input string tag);
        vectors++;
        if (csr_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s: rdata=%h expected=%h", tag, csr_rdata, exp);
        end
    endtask

    // drive one cycle at the falling edge and predict the word after the next rising edge
    task automatic step(input logic v, input logic [3:0] s, input logic [3:0] a,
                        input logic [3:0] d, input logic w, input logic [31:0] wd,
                        input string tag);
        logic [11:0] setm, clrm;
        item_t it;
        @(negedge clk);
        beat_vld = v; sbe_pulse = s; adr_pulse = a; dbe_pulse = d;
        csr_wr = w; csr_wdata = wd;
        setm  = v ? {d, a, s} : 12'h000;
        clrm  = w ? wd[11:0] : 12'h000;
        model = (model & ~clrm) | setm;
        it.exp = {20'h0, model};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 32'h0, "idle");
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.exp, it.tag);
            end
        end
    end

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: rdata=%h expected=completion", csr_rdata);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(32'h0, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: each lane and kind alone lands at its own bit
        for (int l = 0; l < 4; l++) begin
            step(1'b1, 4'(1 << l), 4'h0, 4'h0, 1'b0, 32'h0, "R2 R3 sbe lane");
            step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0000_0FFF, "R6 clear all");
            step(1'b1, 4'h0, 4'(1 << l), 4'h0, 1'b0, 32'h0, "R2 R3 adr lane");
            step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'hFFFF_FFFF, "R6 R9 clear all");
            step(1'b1, 4'h0, 4'h0, 4'(1 << l), 1'b0, 32'h0, "R2 R3 dbe lane");
            step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0000_0FFF, "R6 clear all");
        end

        // R4: errors without valid beat
        step(1'b0, 4'hF, 4'hF, 4'hF, 1'b0, 32'h0, "R4 invalid beat ignored");
        step(1'b0, 4'h5, 4'hA, 4'h3, 1'b0, 32'h0, "R4 invalid beat ignored");

        // R5: sticky under repeated errors
        step(1'b1, 4'h5, 4'h0, 4'h2, 1'b0, 32'h0, "R3 mixed set");
        step(1'b1, 4'h5, 4'h0, 4'h2, 1'b0, 32'h0, "R5 repeat error");
        idle();
        idle();

        // R7: write zeros changes nothing
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0, "R7 write zero");
        // R9: reserved-only write
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'hFFFF_F000, "R9 reserved write");
        // R6/R10: clear one bit (lane 2 sbe, bit 2), others stay
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0000_0004, "R6 R10 single clear");
        // R10: set a different lane while others held
        step(1'b1, 4'h0, 4'h8, 4'h0, 1'b0, 32'h0, "R10 independent set");

        // R8: set and clear on same bit, plus clear elsewhere
        step(1'b1, 4'h0, 4'h0, 4'h1, 1'b1, 32'h0000_0F01, "R8 set wins");
        step(1'b1, 4'h2, 4'h0, 4'h0, 1'b1, 32'h0000_0002, "R8 set wins new");
        // R8 with invalid beat: clear must win
        step(1'b0, 4'hF, 4'hF, 4'hF, 1'b1, 32'h0000_0FFF, "R4 R6 clear with invalid errs");

        // dense patterns
        step(1'b1, 4'hA, 4'h5, 4'hC, 1'b0, 32'h0, "R2 pattern A");
        step(1'b1, 4'h5, 4'hA, 4'h3, 1'b1, 32'h0000_0A5C, "R8 R10 pattern B");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0000_0555, "R6 R10 partial");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 32'h0000_0AAA, "R6 final clear");
        idle();

        wait (sb.size() == 0);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule